// File: doc/BRIEF.md
# Dual-clock packet commit buffer

This block moves whole packets of 64-bit words from one clock domain to another, unrelated one. On the write side a producer streams words with a write enable and then pulses a commit strobe. The words of a packet stay hidden from the reader until that commit arrives, so the consumer never sees a partial packet.

On the read side the consumer sees a valid flag, the word count of the head packet, and that packet's first word, all before it asks for anything. Each read-enable cycle steps to the next word. When nothing is pending, the read outputs are held at zero.

A write-ready output tells the producer whether a packet of the largest size is guaranteed to fit. The producer checks it before it starts a packet.

Top module: `pkt_cdc_buffer`

## Requirements
- R1: After reset, wr_ready is 1, rd_valid is 0, and both rd_count and rd_data are 0.
- R2: Words accepted on the write side are not visible to the reader until a commit pulse. Without a commit, rd_valid stays 0.
- R3: After a commit, rd_valid rises on the read side within a bounded number of read cycles. While rd_valid is 1, rd_count holds the number of words in the head packet (for example 2 for a two-word packet) and does not change.
- R4: Show-ahead: while rd_valid is 1 and before any rd_en, rd_data already holds the first word of the head packet.
- R5: Each read-clock cycle in which rd_valid and rd_en are both 1 consumes one word. rd_data then moves to the next word of the packet, in the order the words were written.
- R6: After the last word of a packet is consumed, rd_valid is 0 and rd_data and rd_count read 0 on the next cycle. If no other packet is pending, they stay 0 while rd_en remains 1. rd_en has no effect while rd_valid is 0.
- R7: Several committed packets are delivered in commit order. Between two packets there is exactly one read cycle with rd_valid at 0, and the next packet appears on the following cycle.
- R8: wr_ready is 0 in either of two cases. The first is when fewer than 511 free words remain in the 1024-word store, counting only committed words. The second is when 8 committed packets are waiting behind the packet being presented. While wr_ready is 0, words and commits are ignored.
- R9: A commit pulse with no words accepted since the previous commit creates no packet.
- R10: Each domain has its own asynchronous active-low reset. Asserting the resets empties the buffer and forces rd_valid, rd_count and rd_data to 0 at once, without waiting for a clock.
- R11: A word written in the same cycle as the commit pulse belongs to the packet being committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | Word strobe for wr_data |
| wr_data | input | 64 | Word to append to the packet being built |
| wr_commit | input | 1 | Single-cycle pulse that publishes the packet being built |
| wr_ready | output | 1 | Room for one more maximum-size packet |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Consume the current word |
| rd_valid | output | 1 | A committed packet is being presented |
| rd_count | output | 9 | Word count of the presented packet, 0 when idle |
| rd_data | output | 64 | Current word of the presented packet, 0 when idle |

## Verification
The assertions check several properties on every cycle:
- The outputs are zero whenever nothing is presented.
- The count stays fixed while a packet is presented.
- Consuming the final word always drops the valid flag.
- The staging pointer never moves while ready is low.
- Ready never falls while a packet is half written.
- Every crossed pointer changes by at most one Gray bit per source cycle.

Only the directed scenarios can show end-to-end behaviour: that a packet stays hidden until its commit, and that the words come out in order with the right count. They also cover the single idle cycle between queued packets, the two conditions that drop ready, and empty or same-cycle commits.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int PCB_DATA_W  = 64;
    localparam int PCB_ADDR_W  = 10;
    localparam int PCB_LEN_W   = 9;
    localparam int PCB_QUEUE_W = 3;
endpackage

// File: rtl/pcb_gray_cdc.sv
module pcb_gray_cdc #(
    parameter int W = 4
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_bin
);
    logic [W-1:0] gray_q;
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) gray_q <= '0;
        else            gray_q <= src_bin ^ (src_bin >> 1);
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_q;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        dst_bin[W-1] = sync_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            dst_bin[i] = dst_bin[i+1] ^ sync_q[i];
        end
    end

    // the crossing is safe only if a single bit changes per source cycle
    p_gray_step_r3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1)
        else $error("gray pointer moved more than one bit");
endmodule

// File: rtl/pcb_wr_ctrl.sv
module pcb_wr_ctrl #(
    parameter int DW      = 64,
    parameter int AW      = 10,
    parameter int LW      = 9,
    parameter int QW      = 3,
    parameter int MAX_PKT = 511
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_commit,
    input  logic [AW:0]   rd_ptr_sync,
    input  logic [QW:0]   q_rptr_sync,
    output logic          wr_ready,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [DW-1:0] ram_wdata,
    output logic          q_we,
    output logic [QW-1:0] q_waddr,
    output logic [LW-1:0] q_wdata,
    output logic [QW:0]   q_wptr
);
    localparam int DEPTH  = 1 << AW;
    localparam int QDEPTH = 1 << QW;

    typedef struct packed {
        logic [AW:0]   wptr;
        logic [AW:0]   cptr;
        logic [LW-1:0] len;
        logic [QW:0]   qptr;
    } wr_st_t;

    wr_st_t        st_d, st_q;
    logic [AW:0]   used_w;
    logic [AW+1:0] free_w;
    logic [QW:0]   qused_w;
    logic          take_w;
    logic          commit_w;

    always_comb begin
        st_d     = st_q;
        used_w   = st_q.cptr - rd_ptr_sync;
        free_w   = (AW+2)'(DEPTH) - {1'b0, used_w};
        qused_w  = st_q.qptr - q_rptr_sync;
        wr_ready = (free_w >= (AW+2)'(MAX_PKT)) && ({1'b0, qused_w} < (QW+2)'(QDEPTH));
        take_w   = wr_en && wr_ready && (st_q.len < LW'(MAX_PKT));
        if (take_w) begin
            st_d.wptr = st_q.wptr + (AW+1)'(1);
            st_d.len  = st_q.len + LW'(1);
        end
        commit_w = wr_commit && wr_ready && (st_d.len != '0);
        q_we     = commit_w;
        q_waddr  = st_q.qptr[QW-1:0];
        q_wdata  = st_d.len;
        if (commit_w) begin
            st_d.cptr = st_d.wptr;
            st_d.len  = '0;
            st_d.qptr = st_q.qptr + (QW+1)'(1);
        end
        ram_we    = take_w;
        ram_waddr = st_q.wptr[AW-1:0];
        ram_wdata = wr_data;
        q_wptr    = st_q.qptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_stage_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> $stable(st_q.wptr))
        else $error("word staged while not ready");

    p_ready_in_pkt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && st_q.len != '0 && !wr_commit) |=> wr_ready)
        else $error("ready dropped inside a packet");

    p_room_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.wptr - rd_ptr_sync} <= (AW+2)'(DEPTH)))
        else $error("store overrun");
endmodule

// File: rtl/pcb_rd_ctrl.sv
module pcb_rd_ctrl #(
    parameter int DW = 64,
    parameter int AW = 10,
    parameter int LW = 9,
    parameter int QW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [QW:0]   q_wptr_sync,
    input  logic [LW-1:0] q_rdata,
    input  logic [DW-1:0] ram_rdata,
    output logic [QW-1:0] q_raddr,
    output logic [AW-1:0] ram_raddr,
    output logic [AW:0]   rd_ptr,
    output logic [QW:0]   q_rptr,
    output logic          rd_valid,
    output logic [LW-1:0] rd_count,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic          valid;
        logic [LW-1:0] count;
        logic [LW-1:0] rem;
        logic [AW:0]   rptr;
        logic [QW:0]   qptr;
    } rd_st_t;

    rd_st_t        st_d, st_q;
    logic [DW-1:0] data_d, data_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.valid) begin
            if (q_wptr_sync != st_q.qptr) begin
                st_d.valid = 1'b1;
                st_d.count = q_rdata;
                st_d.rem   = q_rdata;
                st_d.qptr  = st_q.qptr + (QW+1)'(1);
            end
        end else if (rd_en) begin
            st_d.rptr = st_q.rptr + (AW+1)'(1);
            st_d.rem  = st_q.rem - LW'(1);
            if (st_q.rem == LW'(1)) begin
                st_d.valid = 1'b0;
                st_d.count = '0;
            end
        end
    end

    assign ram_raddr = st_d.rptr[AW-1:0];
    assign q_raddr   = st_q.qptr[QW-1:0];

    always_comb begin
        data_d = st_d.valid ? ram_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            data_q <= '0;
        end else begin
            st_q   <= st_d;
            data_q <= data_d;
        end
    end

    assign rd_ptr   = st_q.rptr;
    assign q_rptr   = st_q.qptr;
    assign rd_valid = st_q.valid;
    assign rd_count = st_q.count;
    assign rd_data  = data_q;

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0 && rd_count == '0))
        else $error("idle outputs not zero");

    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid)) |-> $stable(rd_count))
        else $error("count changed inside a packet");

    p_count_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_count != '0)
        else $error("valid with zero count");

    p_last_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_en && st_q.rem == LW'(1)) |=> !rd_valid)
        else $error("valid held after last word");

    p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_valid) |=> $stable(st_q.rptr))
        else $error("pointer moved in the gap cycle");
endmodule

// File: rtl/pkt_cdc_buffer.sv
module pkt_cdc_buffer #(
    parameter int DW = pcb_pkg::PCB_DATA_W,
    parameter int AW = pcb_pkg::PCB_ADDR_W,
    parameter int LW = pcb_pkg::PCB_LEN_W,
    parameter int QW = pcb_pkg::PCB_QUEUE_W
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_commit,
    output logic          wr_ready,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    output logic          rd_valid,
    output logic [LW-1:0] rd_count,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH   = 1 << AW;
    localparam int QDEPTH  = 1 << QW;
    localparam int MAX_PKT = (1 << LW) - 1;

    logic [DW-1:0] mem_q [DEPTH];
    logic [LW-1:0] lenq_q [QDEPTH];

    logic          ram_we;
    logic [AW-1:0] ram_waddr, ram_raddr;
    logic [DW-1:0] ram_wdata, ram_rdata;
    logic          q_we;
    logic [QW-1:0] q_waddr, q_raddr;
    logic [LW-1:0] q_wdata, q_rdata;
    logic [QW:0]   q_wptr, q_wptr_sync, q_rptr, q_rptr_sync;
    logic [AW:0]   rd_ptr, rd_ptr_sync;

    always_ff @(posedge wr_clk) begin
        if (ram_we) mem_q[ram_waddr] <= ram_wdata;
        if (q_we)   lenq_q[q_waddr]  <= q_wdata;
    end
    assign ram_rdata = mem_q[ram_raddr];
    assign q_rdata   = lenq_q[q_raddr];

    pcb_wr_ctrl #(.DW(DW), .AW(AW), .LW(LW), .QW(QW), .MAX_PKT(MAX_PKT)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_commit(wr_commit), .rd_ptr_sync(rd_ptr_sync), .q_rptr_sync(q_rptr_sync),
        .wr_ready(wr_ready), .ram_we(ram_we), .ram_waddr(ram_waddr),
        .ram_wdata(ram_wdata), .q_we(q_we), .q_waddr(q_waddr),
        .q_wdata(q_wdata), .q_wptr(q_wptr)
    );

    pcb_rd_ctrl #(.DW(DW), .AW(AW), .LW(LW), .QW(QW)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .q_wptr_sync(q_wptr_sync),
        .q_rdata(q_rdata), .ram_rdata(ram_rdata), .q_raddr(q_raddr),
        .ram_raddr(ram_raddr), .rd_ptr(rd_ptr), .q_rptr(q_rptr),
        .rd_valid(rd_valid), .rd_count(rd_count), .rd_data(rd_data)
    );

    pcb_gray_cdc #(.W(QW+1)) u_commit_cdc (
        .src_clk(wr_clk), .src_rst_n(wr_rst_n), .src_bin(q_wptr),
        .dst_clk(rd_clk), .dst_rst_n(rd_rst_n), .dst_bin(q_wptr_sync)
    );

    pcb_gray_cdc #(.W(AW+1)) u_free_cdc (
        .src_clk(rd_clk), .src_rst_n(rd_rst_n), .src_bin(rd_ptr),
        .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .dst_bin(rd_ptr_sync)
    );

    pcb_gray_cdc #(.W(QW+1)) u_pop_cdc (
        .src_clk(rd_clk), .src_rst_n(rd_rst_n), .src_bin(q_rptr),
        .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .dst_bin(q_rptr_sync)
    );
endmodule

// File: tb/pkt_cdc_buffer_bench.sv
`timescale 1ns/100ps
module pkt_cdc_buffer_bench;
    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_commit = 1'b0, rd_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_ready, rd_valid;
    logic [8:0]  rd_count;
    logic [63:0] rd_data;
    int          n_vec = 0, n_bad = 0;
    bit          finished = 1'b0;

    always #2.0 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    pkt_cdc_buffer u_pkt_cdc_buffer (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_commit(wr_commit), .wr_ready(wr_ready), .rd_clk(rd_clk),
        .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_count(rd_count), .rd_data(rd_data)
    );

    function automatic logic [63:0] wv(int id, int idx);
        return {16'(id), 16'hC35A, 32'(idx)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_pkt(input int id, input int n, input bit merged);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_en = 1'b1;
            wr_data = wv(id, i);
            wr_commit = merged && (i == n - 1);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        wr_data = '0;
        wr_commit = !merged;
        @(negedge wr_clk);
        wr_commit = 1'b0;
    endtask

    task automatic wait_valid(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge rd_clk);
            if (rd_valid) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic rd_pkt(input int id, input int n, input bit idle_after, input string req);
        bit seen;
        wait_valid(seen);
        chk(seen, {req, " R3 valid rises"}, 64'(rd_valid), 64'd1);
        chk(rd_count == 9'(n), {req, " R3 count"}, 64'(rd_count), 64'(n));
        for (int i = 0; i < n; i++) begin
            chk(rd_data == wv(id, i), (i == 0) ? {req, " R4 first word"} : {req, " R5 word"},
                rd_data, wv(id, i));
            if (i > 0) chk(rd_count == 9'(n), {req, " R3 count held"}, 64'(rd_count), 64'(n));
            rd_en = 1'b1;
            @(negedge rd_clk);
        end
        chk(!rd_valid && rd_data == '0 && rd_count == '0, {req, " R6 zero after last"},
            {rd_data[62:0], rd_valid}, 64'd0);
        if (idle_after) begin
            @(negedge rd_clk);
            chk(!rd_valid && rd_data == '0 && rd_count == '0, {req, " R6 zero with rd_en held"},
                {rd_data[62:0], rd_valid}, 64'd0);
        end
        rd_en = 1'b0;
    endtask

    task automatic t_reset_state();
        chk(wr_ready == 1'b1, "R1 ready", 64'(wr_ready), 64'd1);
        chk(rd_valid == 1'b0, "R1 valid", 64'(rd_valid), 64'd0);
        chk(rd_count == '0, "R1 count", 64'(rd_count), 64'd0);
        chk(rd_data == '0, "R1 data", rd_data, 64'd0);
    endtask

    task automatic t_hidden_until_commit();
        for (int i = 0; i < 3; i++) begin
            @(negedge wr_clk);
            wr_en = 1'b1;
            wr_data = wv(1, i);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        repeat (40) @(negedge rd_clk);
        chk(rd_valid == 1'b0, "R2 no commit no packet", 64'(rd_valid), 64'd0);
        @(negedge wr_clk);
        wr_commit = 1'b1;
        @(negedge wr_clk);
        wr_commit = 1'b0;
        rd_pkt(1, 3, 1'b1, "R2 committed");
    endtask

    task automatic t_two_word();
        wr_pkt(2, 2, 1'b0);
        rd_pkt(2, 2, 1'b1, "single");
    endtask

    task automatic t_empty_commit();
        @(negedge wr_clk);
        wr_commit = 1'b1;
        @(negedge wr_clk);
        wr_commit = 1'b0;
        repeat (40) @(negedge rd_clk);
        chk(rd_valid == 1'b0, "R9 empty commit", 64'(rd_valid), 64'd0);
    endtask

    task automatic t_queued();
        wr_pkt(3, 1, 1'b0);
        wr_pkt(4, 4, 1'b1);
        wr_pkt(5, 2, 1'b0);
        repeat (20) @(negedge rd_clk);
        rd_pkt(3, 1, 1'b0, "R7 first");
        rd_pkt(4, 4, 1'b0, "R7 R11 second");
        rd_pkt(5, 2, 1'b1, "R7 third");
    endtask

    task automatic t_word_space();
        bit seen;
        wr_pkt(20, 511, 1'b0);
        chk(wr_ready == 1'b1, "R8 room after one big", 64'(wr_ready), 64'd1);
        wr_pkt(21, 511, 1'b0);
        @(negedge wr_clk);
        chk(wr_ready == 1'b0, "R8 ready low when full", 64'(wr_ready), 64'd0);
        wr_pkt(22, 3, 1'b0);
        rd_pkt(20, 511, 1'b0, "R8 big one");
        rd_pkt(21, 511, 1'b1, "R8 big two");
        wait_valid(seen);
        chk(!seen, "R8 ignored writes make no packet", 64'(seen), 64'd0);
        repeat (10) @(negedge wr_clk);
        chk(wr_ready == 1'b1, "R8 ready after drain", 64'(wr_ready), 64'd1);
    endtask

    task automatic t_queue_space();
        int n = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge wr_clk);
            if (!wr_ready) break;
            wr_pkt(40 + k, 1, 1'b0);
            repeat (20) @(negedge wr_clk);
            n++;
        end
        chk(n == 9, "R8 packets accepted before queue full", 64'(n), 64'd9);
        chk(wr_ready == 1'b0, "R8 ready low on queue full", 64'(wr_ready), 64'd0);
        for (int k = 0; k < n; k++) rd_pkt(40 + k, 1, k == n - 1, "R8 queued");
        repeat (10) @(negedge wr_clk);
        chk(wr_ready == 1'b1, "R8 ready after queue drain", 64'(wr_ready), 64'd1);
    endtask

    task automatic t_async_reset();
        bit seen;
        wr_pkt(60, 2, 1'b0);
        wait_valid(seen);
        chk(seen, "R10 packet before reset", 64'(seen), 64'd1);
        #1.3;
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        #0.5;
        chk(!rd_valid && rd_count == '0 && rd_data == '0, "R10 outputs cleared",
            {rd_data[62:0], rd_valid}, 64'd0);
        repeat (3) @(negedge rd_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (30) @(negedge rd_clk);
        chk(rd_valid == 1'b0, "R10 buffer empty", 64'(rd_valid), 64'd0);
        chk(wr_ready == 1'b1, "R10 ready", 64'(wr_ready), 64'd1);
    endtask

    initial begin
        repeat (4) @(negedge rd_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        @(negedge wr_clk);
        t_reset_state();
        t_hidden_until_commit();
        t_two_word();
        t_empty_commit();
        t_queued();
        t_word_space();
        t_queue_space();
        t_async_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule